// File: doc/BRIEF.md
# Vectored Interrupt Controller with Grouped Sources

This block collects interrupt requests for a small processor core and decides which one the core services next. Two external pins pass through a synchronizer and a programmable edge detector. A set of internal peripheral pulses raise their own request flags directly. A further set of internal pulses is gathered into shared group lines, and each group line carries one flag of its own. Every line has an enable bit. A single master enable gates all lines.

When the core reports that it can accept an interrupt and its return stack has room, the block picks the pending, enabled line with the lowest index. It registers that line's vector address and raises a one-cycle take strobe. On the next clock edge it clears the master enable and the taken line's flag. Sub-flags inside a group are left untouched, so software must clear them. A simple register port lets software write and read the master enable, line enables, line flags, edge modes, pin configuration, sub-enables and sub-flags.

Top module: `intc_top`

## Requirements
- R1: After reset every register reads 0 and `irq_take` is low.
- R2: Line i has vector address 0x04 + 4*i. Lines 0..1 are external pins 0..1. Lines 2..8 are `dir_req[0..6]`. Lines 9..11 are groups 0..2, so the vectors span 0x04 to 0x30.
- R3: When several lines are eligible in the same cycle, the line with the lowest index is taken.
- R4: A line is taken only when all of the following hold: the master enable is set, the line's enable is set, the line's flag is set, `cpu_ready` is high and `stack_full` is low. A line that is blocked keeps its flag.
- R5: `irq_take` is high for exactly one cycle, with `irq_vec` valid in that cycle. On the next clock edge the master enable and the taken line's flag are cleared.
- R6: Each external pin has a 2-bit edge mode in register 3, at bits [2i+1:2i]: 00 off, 01 rising, 10 falling, 11 both. Only a transition that matches the mode sets the pin's line flag.
- R7: An external pin can set its flag only when both its select bit (register 4, bit i) and its input-direction bit (register 4, bit 2+i) are 1.
- R8: A `sub_req` pulse sets its sub-flag (register 6; group g, member s at bit 3g+s). Sub-flags persist through service and clear only by software write. A group line's flag sets when the OR of its sub-flags, each masked by its sub-enable (register 5, same bit layout), rises from 0 to 1.
- R9: A hardware set of a line flag in the same cycle as a software write of 0 to that flag leaves the flag set.
- R10: Register map: 0 holds the master enable in bit 0; 1 holds the line enables; 2 holds the line flags (line i at bit i); 3 holds the edge modes; 4 holds the pin configuration; 5 holds the sub-enables; 6 holds the sub-flags. Reads return the same layout, with unused bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 2 | External interrupt pins (asynchronous) |
| dir_req | input | 7 | Direct internal request pulses |
| sub_req | input | 9 | Group member request pulses |
| cpu_ready | input | 1 | Core can accept an interrupt |
| stack_full | input | 1 | Core return stack is full |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| irq_take | output | 1 | One-cycle interrupt call strobe |
| irq_vec | output | 8 | Vector address of the taken line |

## Verification
The bench builds the block with its default parameters: two pins, seven direct sources and three groups of three members. That gives twelve lines, so both the first vector (0x04) and the last (0x30) can be reached. Pin 0 is driven through all four edge modes and every pin-configuration gate. The groups are driven to show that sub-flags outlive service and that raising a sub-enable over a pending sub-flag triggers a group request. A write of 0 that collides with a hardware set in the same cycle is also exercised.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] REG_CTRL     = 3'd0;
  localparam logic [REG_AW-1:0] REG_LINE_EN  = 3'd1;
  localparam logic [REG_AW-1:0] REG_LINE_FLG = 3'd2;
  localparam logic [REG_AW-1:0] REG_EDGE     = 3'd3;
  localparam logic [REG_AW-1:0] REG_PIN      = 3'd4;
  localparam logic [REG_AW-1:0] REG_SUB_EN   = 3'd5;
  localparam logic [REG_AW-1:0] REG_SUB_FLG  = 3'd6;
endpackage

// File: rtl/intc_edge_det.sv
module intc_edge_det
  import intc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  edge_mode_e mode,
  input  logic       active,
  output logic       hit
);
  logic s1_q, s2_q, prev_q;
  logic s1_d, s2_d, prev_d;
  logic rise, fall, match;

  always_comb begin
    s1_d   = pin;
    s2_d   = s1_q;
    prev_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    rise = s2_q & ~prev_q;
    fall = ~s2_q & prev_q;
    case (mode)
      EDGE_RISE: match = rise;
      EDGE_FALL: match = fall;
      EDGE_BOTH: match = rise | fall;
      default:   match = 1'b0;
    endcase
    hit = match & active;
  end
endmodule

// File: rtl/intc_group.sv
module intc_group #(
  parameter int N_SUB = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SUB-1:0] sub_req,
  input  logic [N_SUB-1:0] sub_en,
  input  logic             sw_wr,
  input  logic [N_SUB-1:0] sw_data,
  output logic [N_SUB-1:0] sub_flag,
  output logic             grp_set
);
  logic [N_SUB-1:0] flag_q, flag_d;
  logic             lvl_q, lvl_d;

  always_comb begin
    flag_d = flag_q;
    if (sw_wr) flag_d = sw_data;
    flag_d = flag_d | sub_req;
    lvl_d  = |(flag_q & sub_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      lvl_q  <= lvl_d;
    end
  end

  assign sub_flag = flag_q;
  assign grp_set  = lvl_d & ~lvl_q;
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int N_LINES  = 12,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4,
  localparam int IDX_W   = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx,
  output logic [VEC_W-1:0]   vec
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
    vec = VEC_W'(VEC_BASE + VEC_STEP * int'(idx));
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int N_EXT    = 2,
  parameter int N_DIR    = 7,
  parameter int N_GRP    = 3,
  parameter int N_SUB    = 3,
  parameter int DATA_W   = 16,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_EXT-1:0]       ext_pin,
  input  logic [N_DIR-1:0]       dir_req,
  input  logic [N_GRP*N_SUB-1:0] sub_req,
  input  logic                   cpu_ready,
  input  logic                   stack_full,
  input  logic                   wr_en,
  input  logic [REG_AW-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [REG_AW-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   irq_take,
  output logic [VEC_W-1:0]       irq_vec
);
  localparam int N_LINES = N_EXT + N_DIR + N_GRP;
  localparam int N_SUBS  = N_GRP * N_SUB;
  localparam int IDX_W   = $clog2(N_LINES);
  localparam int GRP_LO  = N_EXT + N_DIR;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q   <= 1'b0;
      rst_sync_n_q <= 1'b0;
    end else begin
      rst_meta_q   <= 1'b1;
      rst_sync_n_q <= rst_meta_q;
    end
  end

  // registers
  logic                 gie_q, gie_d;
  logic [N_LINES-1:0]   en_q, en_d;
  logic [N_LINES-1:0]   flag_q, flag_d;
  logic [2*N_EXT-1:0]   edge_q, edge_d;
  logic [N_EXT-1:0]     psel_q, psel_d;
  logic [N_EXT-1:0]     pin_q, pin_d;
  logic [N_SUBS-1:0]    sen_q, sen_d;
  logic                 take_q, take_d;
  logic [VEC_W-1:0]     vec_q, vec_d;
  logic [IDX_W-1:0]     tidx_q, tidx_d;

  logic [N_LINES-1:0]   line_set;
  logic [N_SUBS-1:0]    sub_flags;
  logic [N_LINES-1:0]   eligible;
  logic                 pick_any;
  logic [IDX_W-1:0]     pick_idx;
  logic [VEC_W-1:0]     pick_vec;
  logic                 wr_ctrl, wr_en_r, wr_flg, wr_edge, wr_pin, wr_sen, wr_sflg;
  logic                 unused_wr_bits;

  assign unused_wr_bits = ^wr_data;

  always_comb begin
    wr_ctrl = wr_en && (wr_addr == REG_CTRL);
    wr_en_r = wr_en && (wr_addr == REG_LINE_EN);
    wr_flg  = wr_en && (wr_addr == REG_LINE_FLG);
    wr_edge = wr_en && (wr_addr == REG_EDGE);
    wr_pin  = wr_en && (wr_addr == REG_PIN);
    wr_sen  = wr_en && (wr_addr == REG_SUB_EN);
    wr_sflg = wr_en && (wr_addr == REG_SUB_FLG);
  end

  // external pins
  genvar gi;
  generate
    for (gi = 0; gi < N_EXT; gi++) begin : g_ext
      intc_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_sync_n_q),
        .pin    (ext_pin[gi]),
        .mode   (edge_mode_e'(edge_q[2*gi +: 2])),
        .active (psel_q[gi] & pin_q[gi]),
        .hit    (line_set[gi])
      );
    end
  endgenerate

  assign line_set[GRP_LO-1:N_EXT] = dir_req;

  // multi-source groups
  generate
    for (gi = 0; gi < N_GRP; gi++) begin : g_grp
      intc_group #(.N_SUB(N_SUB)) u_grp (
        .clk      (clk),
        .rst_n    (rst_sync_n_q),
        .sub_req  (sub_req[gi*N_SUB +: N_SUB]),
        .sub_en   (sen_q[gi*N_SUB +: N_SUB]),
        .sw_wr    (wr_sflg),
        .sw_data  (wr_data[gi*N_SUB +: N_SUB]),
        .sub_flag (sub_flags[gi*N_SUB +: N_SUB]),
        .grp_set  (line_set[GRP_LO + gi])
      );
    end
  endgenerate

  // priority selection
  assign eligible = {N_LINES{gie_q}} & en_q & flag_q;

  intc_pick #(
    .N_LINES  (N_LINES),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) u_pick (
    .req (eligible),
    .any (pick_any),
    .idx (pick_idx),
    .vec (pick_vec)
  );

  // next state
  always_comb begin
    gie_d  = gie_q;
    en_d   = en_q;
    flag_d = flag_q;
    edge_d = edge_q;
    psel_d = psel_q;
    pin_d  = pin_q;
    sen_d  = sen_q;
    if (wr_ctrl) gie_d  = wr_data[0];
    if (wr_en_r) en_d   = wr_data[N_LINES-1:0];
    if (wr_flg)  flag_d = wr_data[N_LINES-1:0];
    if (wr_edge) edge_d = wr_data[2*N_EXT-1:0];
    if (wr_pin) begin
      psel_d = wr_data[N_EXT-1:0];
      pin_d  = wr_data[2*N_EXT-1:N_EXT];
    end
    if (wr_sen) sen_d = wr_data[N_SUBS-1:0];
    // service clearing on the edge after the take strobe
    if (take_q) begin
      gie_d          = 1'b0;
      flag_d[tidx_q] = 1'b0;
    end
    // hardware set wins over any clear
    flag_d = flag_d | line_set;

    take_d = cpu_ready & ~stack_full & ~take_q & pick_any;
    vec_d  = take_d ? pick_vec : vec_q;
    tidx_d = take_d ? pick_idx : tidx_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n_q) begin
    if (!rst_sync_n_q) begin
      gie_q  <= 1'b0;
      en_q   <= '0;
      flag_q <= '0;
      edge_q <= '0;
      psel_q <= '0;
      pin_q  <= '0;
      sen_q  <= '0;
      take_q <= 1'b0;
      vec_q  <= '0;
      tidx_q <= '0;
    end else begin
      gie_q  <= gie_d;
      en_q   <= en_d;
      flag_q <= flag_d;
      edge_q <= edge_d;
      psel_q <= psel_d;
      pin_q  <= pin_d;
      sen_q  <= sen_d;
      take_q <= take_d;
      vec_q  <= vec_d;
      tidx_q <= tidx_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_CTRL:     rd_data[0] = gie_q;
      REG_LINE_EN:  rd_data[N_LINES-1:0] = en_q;
      REG_LINE_FLG: rd_data[N_LINES-1:0] = flag_q;
      REG_EDGE:     rd_data[2*N_EXT-1:0] = edge_q;
      REG_PIN:      rd_data[2*N_EXT-1:0] = {pin_q, psel_q};
      REG_SUB_EN:   rd_data[N_SUBS-1:0] = sen_q;
      REG_SUB_FLG:  rd_data[N_SUBS-1:0] = sub_flags;
      default:      rd_data = '0;
    endcase
  end

  assign irq_take = take_q;
  assign irq_vec  = vec_q;
endmodule

// File: rtl/intc_top_chk.sv
module intc_top_chk
  import intc_pkg::*;
#(
  parameter int N_LINES  = 12,
  parameter int N_SUBS   = 9,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_take,
  input logic [VEC_W-1:0]   irq_vec,
  input logic               gie_q,
  input logic               cpu_ready,
  input logic               stack_full,
  input logic [N_LINES-1:0] line_set,
  input logic [N_LINES-1:0] flag_q,
  input logic [N_SUBS-1:0]  sub_flags,
  input logic               wr_en,
  input logic [REG_AW-1:0]  wr_addr
);
  assert_take_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !irq_take);

  assert_gie_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !gie_q);

  assert_take_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $past(gie_q && cpu_ready && !stack_full));

  assert_vec_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (int'(irq_vec) >= VEC_BASE) &&
                 (int'(irq_vec) <= VEC_BASE + VEC_STEP * (N_LINES - 1)) &&
                 (((int'(irq_vec) - VEC_BASE) % VEC_STEP) == 0));

  assert_sub_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(sub_flags) & ~sub_flags)) |-> $past(wr_en && (wr_addr == REG_SUB_FLG)));

  assert_hw_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & $past(line_set)) == $past(line_set));
endmodule

bind intc_top intc_top_chk #(
  .N_LINES  (N_LINES),
  .N_SUBS   (N_SUBS),
  .VEC_W    (VEC_W),
  .VEC_BASE (VEC_BASE),
  .VEC_STEP (VEC_STEP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n_q),
  .irq_take   (irq_take),
  .irq_vec    (irq_vec),
  .gie_q      (gie_q),
  .cpu_ready  (cpu_ready),
  .stack_full (stack_full),
  .line_set   (line_set),
  .flag_q     (flag_q),
  .sub_flags  (sub_flags),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr)
);

// File: tb/intc_top_tb.sv
`timescale 1ns/1ps
module intc_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  ext_pin;
  logic [6:0]  dir_req;
  logic [8:0]  sub_req;
  logic        cpu_ready, stack_full, wr_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic        irq_take;
  logic [7:0]  irq_vec;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [7:0] exp_vec[$];
  string      exp_tag[$];

  always #2.5 clk = ~clk;

  intc_top u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .dir_req(dir_req),
    .sub_req(sub_req), .cpu_ready(cpu_ready), .stack_full(stack_full),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_take(irq_take), .irq_vec(irq_vec)
  );

  // monitor: pops one expectation per take strobe
  always @(negedge clk) begin
    if (rst_n && irq_take) begin
      n_cmp++;
      if (exp_vec.size() == 0) begin
        n_bad++;
        $display("FAIL R4 unexpected take: actual vec=%h expected none", irq_vec);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_vec.pop_front();
        t = exp_tag.pop_front();
        if (irq_vec !== e) begin
          n_bad++;
          $display("FAIL %s vector: actual %h expected %h", t, irq_vec, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_take(input logic [7:0] v, input string t);
    exp_vec.push_back(v);
    exp_tag.push_back(t);
  endtask

  task automatic drain(input string t);
    idle(8);
    n_cmp++;
    if (exp_vec.size() != 0) begin
      n_bad++;
      $display("FAIL %s missing take: actual none expected %h", t, exp_vec[0]);
      exp_vec.delete();
      exp_tag.delete();
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(input logic [2:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    rd_addr = a;
    #0.5;
    n_cmp++;
    if (rd_data !== e) begin
      n_bad++;
      $display("FAIL %s reg %0d: actual %h expected %h", t, a, rd_data, e);
    end
  endtask

  task automatic pulse_dir(input int i);
    @(negedge clk); dir_req[i] = 1'b1;
    @(negedge clk); dir_req = '0;
  endtask

  task automatic pulse_sub(input int i);
    @(negedge clk); sub_req[i] = 1'b1;
    @(negedge clk); sub_req = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ext_pin = '0; dir_req = '0; sub_req = '0;
    cpu_ready = 1'b1; stack_full = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    for (int a = 0; a < 7; a++) rdchk(3'(a), 16'h0, "R1");
    n_cmp++;
    if (irq_take !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 take: actual %b expected 0", irq_take);
    end

    // R10 configuration and readback
    wr(3'd1, 16'h0FFF);
    wr(3'd4, 16'h000F);
    wr(3'd3, 16'h0009);
    rdchk(3'd1, 16'h0FFF, "R10 enables");
    rdchk(3'd4, 16'h000F, "R10 pin cfg");
    rdchk(3'd3, 16'h0009, "R10 edge");

    // R2 / R5 direct line 5
    wr(3'd0, 16'h1);
    expect_take(8'h18, "R2");
    pulse_dir(3);
    idle(8);
    rdchk(3'd0, 16'h0, "R5 master cleared");
    rdchk(3'd2, 16'h0, "R5 flag cleared");
    drain("R2");

    // R4 master enable off, then stack full
    pulse_dir(0);
    drain("R4 master off");
    rdchk(3'd2, 16'h0004, "R4 flag kept");
    stack_full = 1'b1;
    wr(3'd0, 16'h1);
    drain("R4 stack full");
    expect_take(8'h0C, "R4 stack release");
    @(negedge clk); stack_full = 1'b0;
    drain("R4 stack release");

    // R3 priority
    pulse_dir(6);
    pulse_dir(1);
    expect_take(8'h10, "R3 first");
    wr(3'd0, 16'h1);
    idle(8);
    expect_take(8'h24, "R3 second");
    wr(3'd0, 16'h1);
    drain("R3");

    // R4 line enable off
    wr(3'd1, 16'h0FEF);
    pulse_dir(2);
    wr(3'd0, 16'h1);
    drain("R4 enable off");
    rdchk(3'd2, 16'h0010, "R4 disabled flag kept");
    wr(3'd2, 16'h0);
    wr(3'd1, 16'h0FFF);
    rdchk(3'd2, 16'h0, "R10 flag write");

    // R6 edge modes on pin 0 (rising) and pin 1 (falling)
    expect_take(8'h04, "R6 rise");
    ext_pin[0] = 1'b1;
    drain("R6 rise");
    wr(3'd0, 16'h1);
    ext_pin[0] = 1'b0;
    drain("R6 fall ignored");
    rdchk(3'd2, 16'h0, "R6 fall ignored");
    ext_pin[1] = 1'b1;
    drain("R6 pin1 rise ignored");
    expect_take(8'h08, "R6 pin1 fall");
    ext_pin[1] = 1'b0;
    drain("R6 pin1 fall");
    wr(3'd0, 16'h1);
    wr(3'd3, 16'h000B);
    expect_take(8'h04, "R6 both rise");
    ext_pin[0] = 1'b1;
    drain("R6 both rise");
    wr(3'd0, 16'h1);
    expect_take(8'h04, "R6 both fall");
    ext_pin[0] = 1'b0;
    drain("R6 both fall");
    wr(3'd0, 16'h1);
    wr(3'd3, 16'h0008);
    ext_pin[0] = 1'b1; idle(8);
    ext_pin[0] = 1'b0;
    drain("R6 off");
    rdchk(3'd2, 16'h0, "R6 off");

    // R7 pin gating
    wr(3'd3, 16'h0009);
    wr(3'd4, 16'h000B);
    ext_pin[0] = 1'b1;
    drain("R7 not input");
    rdchk(3'd2, 16'h0, "R7 not input");
    ext_pin[0] = 1'b0; idle(6);
    wr(3'd4, 16'h000E);
    ext_pin[0] = 1'b1;
    drain("R7 not selected");
    rdchk(3'd2, 16'h0, "R7 not selected");
    ext_pin[0] = 1'b0; idle(6);
    wr(3'd4, 16'h000F);

    // R8 groups
    wr(3'd5, 16'h0001);
    expect_take(8'h28, "R8 group0");
    pulse_sub(0);
    drain("R8 group0");
    rdchk(3'd6, 16'h0001, "R8 sub flag kept");
    rdchk(3'd2, 16'h0, "R8 group flag cleared");
    wr(3'd0, 16'h1);
    pulse_sub(1);
    drain("R8 no retrigger");
    rdchk(3'd6, 16'h0003, "R8 sub flags");
    wr(3'd6, 16'h0);
    rdchk(3'd6, 16'h0, "R8 software clear");
    pulse_sub(1);
    drain("R8 masked member");
    rdchk(3'd6, 16'h0002, "R8 masked flag");
    expect_take(8'h28, "R8 enable pending");
    wr(3'd5, 16'h0003);
    drain("R8 enable pending");
    wr(3'd6, 16'h0);
    wr(3'd0, 16'h1);
    wr(3'd5, 16'h0043);
    expect_take(8'h30, "R8 last vector");
    pulse_sub(6);
    drain("R8 last vector");
    wr(3'd6, 16'h0);

    // R9 hardware set against software clear
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'h0; dir_req[4] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; dir_req = '0;
    rdchk(3'd2, 16'h0040, "R9");

    idle(4);
    finish_run();
  end
endmodule